// File: doc/BRIEF.md
# Source-Routed Turn Path Selector

This unit sits in the header path of one switch. It chooses the egress port for a unicast packet whose whole route is carried in the header. That route is a 32-bit sequence of turns. With it come a direction flag and a 5-bit pointer that marks where this hop's turn is found. The switch takes a turn value of K bits, where K depends on how many ports the switch has. It rotates from the ingress port by that turn to find the egress port. It then returns the pointer moved by K, so the next switch reads its own bits.

Outbound packets move the pointer downward and responses move it upward. The turn values are the same in both directions. Because the backward rotation undoes the forward one, a reply retraces its path without knowing where it came from. The unit keeps no state from one packet to the next. The same header on the same ingress port always yields the same result, one clock after the valid strobe.

If the pointer cannot move K bits within the field, the unit reports a route error in place of a port.

Top module: `turn_path_selector`

## Requirements
- R1: Results are registered. `out_valid` is high in the cycle after a cycle with `in_valid` high and is low otherwise. Synchronous reset clears `out_valid`, `out_port`, `out_ptr` and `out_err` to zero.
- R2: A switch with N ports consumes K = ceil(log2 N) turn bits per hop, with a minimum of 1. The default N = 8 gives K = 3.
- R3: Forward (`in_dir` = 0): the turn is bits [ptr-1 : ptr-K] of `in_turns`, read as an unsigned value with bit ptr-1 as its MSB. `out_ptr` = ptr - K.
- R4: Backward (`in_dir` = 1): the turn is bits [ptr+K-1 : ptr] of `in_turns`, with bit ptr+K-1 as its MSB. `out_ptr` = ptr + K.
- R5: Forward egress = (ingress + turn + 1) mod N. A turn of N-1 loops back to the ingress port.
- R6: Backward egress = (ingress - turn - 1) mod N. This returns a forward hop's ingress port when it is given that hop's egress port and the pointer that hop produced.
- R7: A forward header with ptr < K, or a backward header with ptr + K > 31, raises `out_err`. In that case `out_port` = 0 and `out_ptr` equals the incoming pointer unchanged.
- R8: In a cycle with `in_valid` low, `out_valid` goes low and `out_port`, `out_ptr` and `out_err` keep their previous values.
- R9: Turn bits outside this hop's K-bit window, including bit 31, do not affect the result.
- R10: The selector has no memory between packets. Identical inputs give identical outputs whatever was processed before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header fields are valid this cycle |
| in_turns | input | 32 | Turn sequence carried by the packet |
| in_dir | input | 1 | 0 = forward, 1 = backward traversal |
| in_ptr | input | 5 | Turn pointer as received |
| in_port | input | PORT_W (3) | Ingress port number |
| out_valid | output | 1 | Result valid |
| out_port | output | PORT_W (3) | Selected egress port |
| out_ptr | output | 5 | Rewritten turn pointer |
| out_err | output | 1 | Route error: pointer would leave the field |

## Verification
The hardest case to reach from the ports is a backward hop landing exactly on the top of the pointer range. Right next to it is the first backward step that overflows, where the sum of pointer and K no longer fits the 5-bit field. Both can hide a carry lost in the pointer arithmetic. The stimulus puts pointers 28 and 29 side by side in the backward direction with the same turn pattern, and it does the same at the lower end with forward pointers 3 and 2. It also plays forward hops and then their backward mirrors. This shows that the port rotation and the pointer step are exact inverses, including at the wrap from port 0 to port N-1.

// File: rtl/turn_route_pkg.sv
package turn_route_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_BWD = 1'b1
  } trav_dir_e;

  // Turn bits needed to name every egress choice of an n-port switch.
  function automatic int unsigned turn_bits_for(input int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

  // Width of a port index.
  function automatic int unsigned port_bits_for(input int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/turn_window.sv
// Pulls this hop's K-bit turn out of the turn sequence.
module turn_window
  import turn_route_pkg::*;
#(
  parameter int unsigned TURN_W = 32,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned K      = 3
) (
  input  logic [TURN_W-1:0] turns,
  input  logic [PTR_W-1:0]  ptr,
  input  trav_dir_e         dir,
  output logic [K-1:0]      turn
);

  localparam int unsigned BW = PTR_W + 1;

  logic [BW-1:0]     base;
  logic [TURN_W-1:0] shifted;

  always_comb begin
    // Forward reads just below the pointer, backward reads from it upward.
    if (dir == DIR_FWD) base = {1'b0, ptr} - BW'(K);
    else                base = {1'b0, ptr};
    shifted = turns >> base;
    turn    = shifted[K-1:0];
  end

endmodule

// File: rtl/ptr_step.sv
// Moves the turn pointer by K and flags steps that would leave the field.
module ptr_step
  import turn_route_pkg::*;
#(
  parameter int unsigned TURN_W = 32,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned K      = 3
) (
  input  logic [PTR_W-1:0] ptr,
  input  trav_dir_e        dir,
  output logic [PTR_W-1:0] next_ptr,
  output logic             err
);

  localparam int unsigned BW      = PTR_W + 1;
  localparam int unsigned PTR_MAX = (1 << PTR_W) - 1;
  localparam int unsigned LIMIT   = (TURN_W < PTR_MAX) ? TURN_W : PTR_MAX;

  logic [BW-1:0] up_sum;
  logic [BW-1:0] down_diff;

  always_comb begin
    up_sum    = {1'b0, ptr} + BW'(K);
    down_diff = {1'b0, ptr} - BW'(K);
    if (dir == DIR_FWD) begin
      err      = ({1'b0, ptr} < BW'(K)) || ({1'b0, ptr} > BW'(LIMIT));
      next_ptr = down_diff[PTR_W-1:0];
    end else begin
      err      = (up_sum > BW'(LIMIT));
      next_ptr = up_sum[PTR_W-1:0];
    end
  end

  // r7: a step that is not flagged never wraps the pointer.
  always_comb begin
    if (!err && dir == DIR_FWD)
      a_r7_fwd_no_wrap: assert (next_ptr <= ptr);
    if (!err && dir == DIR_BWD)
      a_r7_bwd_no_wrap: assert (next_ptr >= ptr);
  end

endmodule

// File: rtl/port_rotate.sv
// Rotates from the ingress port by turn+1 (forward) or back by turn+1.
module port_rotate
  import turn_route_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned K         = 3
) (
  input  logic [PORT_W-1:0] in_port,
  input  logic [K-1:0]      turn,
  input  trav_dir_e         dir,
  output logic [PORT_W-1:0] out_port
);

  localparam int unsigned W       = PORT_W + K + 2;
  localparam bit          POW2    = (NUM_PORTS == (1 << PORT_W));

  logic [W-1:0] step;
  logic [W-1:0] fwd_sum;
  logic [W-1:0] bwd_sum;
  logic [W-1:0] step_red;

  generate
    if (POW2) begin : g_pow2
      // Modulo a power of two is plain truncation.
      always_comb begin
        step     = W'(turn) + W'(1);
        step_red = '0;
        fwd_sum  = W'(in_port) + step;
        bwd_sum  = W'(in_port) - step;
        if (dir == DIR_FWD) out_port = fwd_sum[PORT_W-1:0];
        else                out_port = bwd_sum[PORT_W-1:0];
      end
    end else begin : g_generic
      always_comb begin
        step     = W'(turn) + W'(1);
        step_red = step % W'(NUM_PORTS);
        fwd_sum  = (W'(in_port) + step) % W'(NUM_PORTS);
        bwd_sum  = (W'(in_port) + W'(NUM_PORTS) - step_red) % W'(NUM_PORTS);
        if (dir == DIR_FWD) out_port = fwd_sum[PORT_W-1:0];
        else                out_port = bwd_sum[PORT_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/turn_path_selector.sv
module turn_path_selector
  import turn_route_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned TURN_W    = 32,
  parameter int unsigned PTR_W     = 5,
  parameter int unsigned K         = turn_bits_for(NUM_PORTS),
  parameter int unsigned PORT_W    = port_bits_for(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TURN_W-1:0] in_turns,
  input  logic              in_dir,
  input  logic [PTR_W-1:0]  in_ptr,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port,
  output logic [PTR_W-1:0]  out_ptr,
  output logic              out_err
);

  trav_dir_e         dir;
  logic [K-1:0]      turn;
  logic [PTR_W-1:0]  next_ptr;
  logic              step_err;
  logic [PORT_W-1:0] rot_port;

  assign dir = trav_dir_e'(in_dir);

  turn_window #(.TURN_W(TURN_W), .PTR_W(PTR_W), .K(K)) u_window (
    .turns (in_turns),
    .ptr   (in_ptr),
    .dir   (dir),
    .turn  (turn)
  );

  ptr_step #(.TURN_W(TURN_W), .PTR_W(PTR_W), .K(K)) u_step (
    .ptr      (in_ptr),
    .dir      (dir),
    .next_ptr (next_ptr),
    .err      (step_err)
  );

  port_rotate #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .K(K)) u_rotate (
    .in_port  (in_port),
    .turn     (turn),
    .dir      (dir),
    .out_port (rot_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_ptr   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err  <= step_err;
        out_port <= step_err ? '0 : rot_port;
        out_ptr  <= step_err ? in_ptr : next_ptr;
      end
    end
  end

  // Assertions
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_port) && $stable(out_ptr) && $stable(out_err)));
  a_r7_err_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_port == '0 && out_ptr == $past(in_ptr)));
  a_r5_port_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_port <= PORT_W'(NUM_PORTS - 1)));
  a_r3_fwd_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dir && in_ptr >= PTR_W'(K)) |=>
      (!out_err && out_ptr == $past(in_ptr) - PTR_W'(K)));
  a_r4_bwd_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dir && (PTR_W+1)'(in_ptr) + (PTR_W+1)'(K) <= (PTR_W+1)'((1 << PTR_W) - 1)) |=>
      (!out_err && out_ptr == $past(in_ptr) + PTR_W'(K)));

endmodule

// File: tb/sim_turn_path_selector.sv
module sim_turn_path_selector;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 14;

  typedef struct packed {
    logic [31:0] turns;
    logic        dir;
    logic [4:0]  ptr;
    logic [2:0]  inp;
    logic [2:0]  eport;
    logic [4:0]  eptr;
    logic        eerr;
  } vec_t;

  // turns, dir, ptr, ingress -> egress, pointer, error   (N = 8, K = 3)
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b0, 5'd31, 3'd0, 3'd1, 5'd28, 1'b0}, // R3 R5 R2
    '{32'h7000_0000, 1'b0, 5'd31, 3'd2, 3'd2, 5'd28, 1'b0}, // R5 loopback
    '{32'h0000_0028, 1'b0, 5'd6,  3'd4, 3'd2, 5'd3,  1'b0}, // R3 R5
    '{32'h0000_0005, 1'b0, 5'd3,  3'd1, 3'd7, 5'd0,  1'b0}, // R3 low edge
    '{32'h0000_0005, 1'b0, 5'd2,  3'd1, 3'd0, 5'd2,  1'b1}, // R7 fwd underflow
    '{32'h0000_0005, 1'b1, 5'd0,  3'd7, 3'd1, 5'd3,  1'b0}, // R4 R6 mirror
    '{32'h0000_0028, 1'b1, 5'd3,  3'd2, 3'd4, 5'd6,  1'b0}, // R6 mirror
    '{32'h7000_0000, 1'b1, 5'd28, 3'd2, 3'd2, 5'd31, 1'b0}, // R4 top edge
    '{32'h7000_0000, 1'b1, 5'd29, 3'd2, 3'd0, 5'd29, 1'b1}, // R7 bwd overflow
    '{32'h0000_0000, 1'b1, 5'd0,  3'd0, 3'd7, 5'd3,  1'b0}, // R6 wrap
    '{32'h0000_0000, 1'b0, 5'd3,  3'd7, 3'd0, 5'd0,  1'b0}, // R5 wrap
    '{32'h8000_0000, 1'b0, 5'd31, 3'd5, 3'd6, 5'd28, 1'b0}, // R9 bit 31
    '{32'hFFFF_FFF8, 1'b0, 5'd3,  3'd3, 3'd4, 5'd0,  1'b0}, // R9 outside bits
    '{32'h0000_0000, 1'b1, 5'd28, 3'd3, 3'd2, 5'd31, 1'b0}  // R4 R6
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_turns = '0;
  logic        in_dir = 1'b0;
  logic [4:0]  in_ptr = '0;
  logic [2:0]  in_port = '0;
  logic        out_valid;
  logic [2:0]  out_port;
  logic [4:0]  out_ptr;
  logic        out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  turn_path_selector u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_turns  (in_turns),
    .in_dir    (in_dir),
    .in_ptr    (in_ptr),
    .in_port   (in_port),
    .out_valid (out_valid),
    .out_port  (out_port),
    .out_ptr   (out_ptr),
    .out_err   (out_err)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1;
    in_turns = v.turns;
    in_dir   = v.dir;
    in_ptr   = v.ptr;
    in_port  = v.inp;
  endtask

  task automatic check_vec(input string req, input vec_t v);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " port"},  int'(out_port),  int'(v.eport));
    check({req, " ptr"},   int'(out_ptr),   int'(v.eptr));
    check({req, " err"},   int'(out_err),   int'(v.eerr));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset port",  int'(out_port),  0);
    check("R1 reset ptr",   int'(out_ptr),   0);
    check("R1 reset err",   int'(out_err),   0);

    @(negedge clk);
    rst = 1'b0;

    // Table walk, back-to-back valid headers
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1;
      check_vec($sformatf("R3/R4/R5/R6/R7 vec%0d", i), VECS[i]);
    end

    // R8: idle cycle with garbage on the inputs holds the last result
    @(negedge clk);
    in_valid = 1'b0;
    in_turns = 32'hDEAD_BEEF;
    in_ptr   = 5'd17;
    in_port  = 3'd6;
    @(posedge clk);
    #1;
    check("R8 idle valid", int'(out_valid), 0);
    check("R8 idle port",  int'(out_port),  2);
    check("R8 idle ptr",   int'(out_ptr),   31);
    check("R8 idle err",   int'(out_err),   0);

    // R1: one cycle of latency, no early output
    @(negedge clk);
    drive(VECS[2]);
    #1;
    check("R1 no early valid", int'(out_valid), 0);
    @(posedge clk);
    #1;
    // R10: same header after a different history gives the same result
    check_vec("R10 repeat", VECS[2]);

    // R9: flipping every bit outside the window leaves the result unchanged
    @(negedge clk);
    drive(VECS[2]);
    in_turns = VECS[2].turns ^ 32'hFFFF_FFC7;
    @(posedge clk);
    #1;
    check_vec("R9 outside window", VECS[2]);

    // R1: reset while valid is high clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset valid", int'(out_valid), 0);
    check("R1 mid reset port",  int'(out_port),  0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    #1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule